// File: doc/BRIEF.md
# Hall-Commutated Three-Phase Drive Controller

This block sits between three digitized Hall sensor levels and the gate drive of a three-phase bridge. Each clock cycle it chooses one of three states for every phase: driven high, driven low, or left floating. In normal running, the Hall code and the direction command pick which phase sources current and which one sinks it. When the PWM command is in its disabled level, the sinking phase is also driven high, so the winding current recirculates through the high side and decays slowly.

Around this commutation core, a small mode controller manages the transitions. A direction reversal while running, or a stop request, first shorts all three phases low for a timed brake period. A current-sense trip replaces the sinking phase with a high drive for a timed interval. Fault inputs override everything in a fixed priority: thermal shutdown, then short circuit, then current limit. The block also produces two tachometer levels derived from the Hall bits.

The command inputs carry pin polarity. Run, direction and PWM all read as inactive when high. Every input passes through a synchronizer before use. The block is driven from a 1 MHz tick clock, and its timed intervals are parameters counted in clock cycles.

Top module: `bldc_drive_ctl`

## Requirements
- R1: Each phase output uses the code 2'b00 = floating, 2'b01 = driven low, 2'b10 = driven high. The code 2'b11 never appears. During reset all phases float and both tach outputs are 1.
- R2: While running with no fault, a Hall code {ab,bc,ca} of 3'b000 or 3'b111 floats all three phases, whatever the PWM level.
- R3: While running with dir_i=0 and pwm_n_i=0, the six valid codes map as follows, written as high/low, with the third phase floating: 001 B/A, 010 C/B, 011 C/A, 100 A/C, 101 B/C, 110 A/B.
- R4: With dir_i=1, the same table applies with the high and low phases exchanged.
- R5: With pwm_n_i=1, both phases that R3/R4 would drive are driven high, and the third phase floats.
- R6: tach_o equals the inverse of the AB Hall bit. tach3_o equals the inverse of ab^bc^ca.
- R7: A change of dir_i while running forces all three phases low for exactly BRAKE_TICKS cycles, after which commutation resumes in the new direction. A further change during the brake restarts it, so two changes d cycles apart give d+BRAKE_TICKS low cycles.
- R8: Raising run_n_i while running gives exactly BRAKE_TICKS cycles of all-low, then all phases float. While stopped, the phases float and dir_i changes cause no brake.
- R9: A one-cycle current-limit pulse while running drives the would-be low phase high for exactly ILIM_TICKS cycles, after which the outputs follow PWM again.
- R10: overtemp_i floats all phases. Otherwise short_i drives all phases low. Both faults override the current-limit override and the Hall map.
- R11: A Hall change reaches the phase outputs on the third rising clock edge after it is applied, and not before.
- R12: Lowering run_n_i from the stopped state starts commutation directly, with no brake, on the fourth rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 1 MHz tick clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hall_ab_i | input | 1 | Hall level, sensor between A and B |
| hall_bc_i | input | 1 | Hall level, sensor between B and C |
| hall_ca_i | input | 1 | Hall level, sensor between C and A |
| dir_i | input | 1 | 0 = clockwise, 1 = counter-clockwise |
| run_n_i | input | 1 | 0 = run, 1 = stop |
| pwm_n_i | input | 1 | 0 = drive enabled, 1 = high-side recirculation |
| ilim_i | input | 1 | Current-sense comparator trip |
| short_i | input | 1 | Short-circuit detector flag |
| overtemp_i | input | 1 | Thermal shutdown flag |
| phase_a_o | output | 2 | Phase A state code |
| phase_b_o | output | 2 | Phase B state code |
| phase_c_o | output | 2 | Phase C state code |
| tach_o | output | 1 | Inverted AB Hall level |
| tach3_o | output | 1 | Inverted XOR of all Hall levels |

## Verification
The properties assume every input is a level that stays put for at least one clock. They also assume fault flags are ordinary digital levels, so a thermal or short flag seen after synchronization is acted on in the next cycle. The brake and override properties further assume the direction and run inputs do not toggle faster than the synchronizer, which would hide a flip. The stimulus respects all of this: it changes inputs only on falling edges, holds every command for several cycles, and makes the only one-cycle pulse the current-limit trip, whose override length is measured.

// File: rtl/bldc_pkg.sv
package bldc_pkg;

  typedef enum logic [1:0] {
    PH_OFF  = 2'b00,
    PH_LOW  = 2'b01,
    PH_HIGH = 2'b10
  } ph_e;

  typedef enum logic [1:0] {
    M_IDLE  = 2'b00,
    M_RUN   = 2'b01,
    M_BRAKE = 2'b10
  } mode_e;

  typedef struct packed {
    ph_e a;
    ph_e b;
    ph_e c;
  } bridge_t;

  localparam logic [1:0] IDX_A    = 2'd0;
  localparam logic [1:0] IDX_B    = 2'd1;
  localparam logic [1:0] IDX_C    = 2'd2;
  localparam logic [1:0] IDX_NONE = 2'd3;

endpackage

// File: rtl/bldc_sync.sv
module bldc_sync #(
  parameter int          WIDTH  = 3,
  parameter int          STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= RST_VAL;
    else        chain_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[s] <= RST_VAL;
      else        chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/bldc_commute.sv
module bldc_commute
  import bldc_pkg::*;
(
  input  logic [2:0] hall_i,   // {ab, bc, ca}
  input  logic       ccw_i,
  input  logic       recirc_i,
  output bridge_t    drive_o
);
  logic [1:0] src_cw, snk_cw, src_idx, snk_idx;
  ph_e        ph [3];

  always_comb begin
    unique case (hall_i)
      3'b001: begin src_cw = IDX_B; snk_cw = IDX_A; end
      3'b010: begin src_cw = IDX_C; snk_cw = IDX_B; end
      3'b011: begin src_cw = IDX_C; snk_cw = IDX_A; end
      3'b100: begin src_cw = IDX_A; snk_cw = IDX_C; end
      3'b101: begin src_cw = IDX_B; snk_cw = IDX_C; end
      3'b110: begin src_cw = IDX_A; snk_cw = IDX_B; end
      default: begin src_cw = IDX_NONE; snk_cw = IDX_NONE; end
    endcase
  end

  // Reversal exchanges source and sink phases
  assign src_idx = ccw_i ? snk_cw : src_cw;
  assign snk_idx = ccw_i ? src_cw : snk_cw;

  for (genvar p = 0; p < 3; p++) begin : g_phase
    always_comb begin
      if (src_idx == 2'(p))      ph[p] = PH_HIGH;
      else if (snk_idx == 2'(p)) ph[p] = recirc_i ? PH_HIGH : PH_LOW;
      else                       ph[p] = PH_OFF;
    end
  end

  assign drive_o.a = ph[0];
  assign drive_o.b = ph[1];
  assign drive_o.c = ph[2];
endmodule

// File: rtl/bldc_mode_ctl.sv
module bldc_mode_ctl
  import bldc_pkg::*;
#(
  parameter int BRAKE_TICKS = 20000,
  parameter int ILIM_TICKS  = 40
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run_n_i,
  input  logic  dir_i,
  input  logic  ilim_i,
  output mode_e mode_o,
  output logic  ovr_o
);
  localparam int BW = $clog2(BRAKE_TICKS + 1);
  localparam int OW = $clog2(ILIM_TICKS + 1);

  mode_e         mode_q, mode_d;
  logic          dir_prev_q, flip;
  logic [BW-1:0] brk_cnt_q;
  logic [OW-1:0] ovr_cnt_q;
  logic          ovr_q, brk_done;

  assign flip     = dir_i ^ dir_prev_q;
  assign brk_done = (brk_cnt_q == BW'(BRAKE_TICKS - 1));

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      M_IDLE:  if (!run_n_i) mode_d = M_RUN;
      M_RUN:   if (run_n_i || flip) mode_d = M_BRAKE;
      M_BRAKE: if (!flip && brk_done) mode_d = run_n_i ? M_IDLE : M_RUN;
      default: mode_d = M_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= M_IDLE;
      dir_prev_q <= 1'b1;
      brk_cnt_q  <= '0;
    end else begin
      mode_q     <= mode_d;
      dir_prev_q <= dir_i;
      if (mode_q != M_BRAKE || flip) brk_cnt_q <= '0;
      else                           brk_cnt_q <= brk_cnt_q + 1'b1;
    end
  end

  // Current-limit override: timed, only while running
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q     <= 1'b0;
      ovr_cnt_q <= '0;
    end else if (mode_d != M_RUN || mode_q != M_RUN) begin
      ovr_q     <= 1'b0;
      ovr_cnt_q <= '0;
    end else if (ovr_q) begin
      ovr_cnt_q <= ovr_cnt_q + 1'b1;
      if (ovr_cnt_q == OW'(ILIM_TICKS - 1)) ovr_q <= 1'b0;
    end else if (ilim_i) begin
      ovr_q     <= 1'b1;
      ovr_cnt_q <= '0;
    end
  end

  assign mode_o = mode_q;
  assign ovr_o  = ovr_q;

  a_r8_stop_via_brake: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RUN) |=> (mode_q != M_IDLE));

  a_r7_flip_brakes: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RUN && flip) |=> (mode_q == M_BRAKE));

  a_r9_ovr_only_run: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |-> (mode_q == M_RUN));

  a_r12_start_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_IDLE) |=> (mode_q != M_BRAKE));
endmodule

// File: rtl/bldc_drive_ctl.sv
module bldc_drive_ctl
  import bldc_pkg::*;
#(
  parameter int BRAKE_TICKS = 20000,
  parameter int ILIM_TICKS  = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hall_ab_i,
  input  logic       hall_bc_i,
  input  logic       hall_ca_i,
  input  logic       dir_i,
  input  logic       run_n_i,
  input  logic       pwm_n_i,
  input  logic       ilim_i,
  input  logic       short_i,
  input  logic       overtemp_i,
  output logic [1:0] phase_a_o,
  output logic [1:0] phase_b_o,
  output logic [1:0] phase_c_o,
  output logic       tach_o,
  output logic       tach3_o
);
  logic [2:0] hall_s, cmd_s, flt_s;
  logic       dir_s, run_n_s, pwm_n_s, ilim_s, short_s, hot_s;
  mode_e      mode;
  logic       ovr;
  bridge_t    comm, drv_d, drv_q;
  logic       tach_q, tach3_q;

  bldc_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b000)) u_sync_hall (
    .clk(clk), .rst_n(rst_n),
    .d_i({hall_ab_i, hall_bc_i, hall_ca_i}), .q_o(hall_s));

  bldc_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync_cmd (
    .clk(clk), .rst_n(rst_n),
    .d_i({dir_i, run_n_i, pwm_n_i}), .q_o(cmd_s));

  bldc_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b000)) u_sync_flt (
    .clk(clk), .rst_n(rst_n),
    .d_i({ilim_i, short_i, overtemp_i}), .q_o(flt_s));

  assign {dir_s, run_n_s, pwm_n_s} = cmd_s;
  assign {ilim_s, short_s, hot_s}  = flt_s;

  bldc_mode_ctl #(.BRAKE_TICKS(BRAKE_TICKS), .ILIM_TICKS(ILIM_TICKS)) u_mode (
    .clk(clk), .rst_n(rst_n), .run_n_i(run_n_s), .dir_i(dir_s),
    .ilim_i(ilim_s), .mode_o(mode), .ovr_o(ovr));

  bldc_commute u_comm (
    .hall_i(hall_s), .ccw_i(dir_s), .recirc_i(pwm_n_s | ovr), .drive_o(comm));

  // Fault priority: thermal, short, then mode
  always_comb begin
    if (hot_s)                drv_d = '{a: PH_OFF, b: PH_OFF, c: PH_OFF};
    else if (short_s)         drv_d = '{a: PH_LOW, b: PH_LOW, c: PH_LOW};
    else if (mode == M_BRAKE) drv_d = '{a: PH_LOW, b: PH_LOW, c: PH_LOW};
    else if (mode == M_RUN)   drv_d = comm;
    else                      drv_d = '{a: PH_OFF, b: PH_OFF, c: PH_OFF};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_q   <= '{a: PH_OFF, b: PH_OFF, c: PH_OFF};
      tach_q  <= 1'b1;
      tach3_q <= 1'b1;
    end else begin
      drv_q   <= drv_d;
      tach_q  <= ~hall_s[2];
      tach3_q <= ~(^hall_s);
    end
  end

  assign phase_a_o = drv_q.a;
  assign phase_b_o = drv_q.b;
  assign phase_c_o = drv_q.c;
  assign tach_o    = tach_q;
  assign tach3_o   = tach3_q;

  a_r1_no_illegal_code: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_a_o != 2'b11) && (phase_b_o != 2'b11) && (phase_c_o != 2'b11));

  a_r10_thermal_floats: assert property (@(posedge clk) disable iff (!rst_n)
    hot_s |=> ({phase_a_o, phase_b_o, phase_c_o} == 6'b00_00_00));

  a_r10_short_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!hot_s && short_s) |=> ({phase_a_o, phase_b_o, phase_c_o} == 6'b01_01_01));

  a_r2_invalid_floats: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_RUN && !hot_s && !short_s && (hall_s == 3'b000 || hall_s == 3'b111))
    |=> ({phase_a_o, phase_b_o, phase_c_o} == 6'b00_00_00));

  a_r6_tach_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (tach_o == ~$past(hall_s[2])));
endmodule

// File: tb/bldc_drive_ctl_tb_top.sv
module bldc_drive_ctl_tb_top;
  localparam int BT = 24;
  localparam int IT = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] hall = 3'b000;
  logic dir = 1'b0, run_n = 1'b1, pwm_n = 1'b0;
  logic ilim = 1'b0, shrt = 1'b0, hot = 1'b0;
  logic [1:0] pa, pb, pc;
  logic tach, tach3;
  int checks = 0, bad = 0;

  always #10 clk = ~clk;

  bldc_drive_ctl #(.BRAKE_TICKS(BT), .ILIM_TICKS(IT)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .hall_ab_i(hall[2]), .hall_bc_i(hall[1]), .hall_ca_i(hall[0]),
    .dir_i(dir), .run_n_i(run_n), .pwm_n_i(pwm_n),
    .ilim_i(ilim), .short_i(shrt), .overtemp_i(hot),
    .phase_a_o(pa), .phase_b_o(pb), .phase_c_o(pc),
    .tach_o(tach), .tach3_o(tach3));

  localparam logic [5:0] ALL_OFF = 6'b00_00_00;
  localparam logic [5:0] ALL_LOW = 6'b01_01_01;

  function automatic logic [5:0] exp_map(logic [2:0] h, logic ccw, logic rec);
    int hi, lo, t;
    logic [1:0] ph [3];
    case (h)
      3'b001: begin hi = 1; lo = 0; end
      3'b010: begin hi = 2; lo = 1; end
      3'b011: begin hi = 2; lo = 0; end
      3'b100: begin hi = 0; lo = 2; end
      3'b101: begin hi = 1; lo = 2; end
      3'b110: begin hi = 0; lo = 1; end
      default: begin hi = -1; lo = -1; end
    endcase
    if (ccw) begin t = hi; hi = lo; lo = t; end
    for (int p = 0; p < 3; p++)
      ph[p] = (p == hi) ? 2'b10 : (p == lo) ? (rec ? 2'b10 : 2'b01) : 2'b00;
    return {ph[0], ph[1], ph[2]};
  endfunction

  function automatic logic [5:0] obs();
    return {pa, pb, pc};
  endfunction

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic count_pat(logic [5:0] pat, int window, output int n);
    n = 0;
    for (int i = 0; i < window; i++) begin
      @(negedge clk);
      if (obs() == pat) n++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'h5EED_0A17));
    // R1: reset state
    step(3);
    chk("R1 reset phases", 32'(obs()), 32'(ALL_OFF));
    chk("R1 reset tach", 32'({tach, tach3}), 32'b11);
    rst_n = 1'b1;
    hall = 3'b001;
    step(6);
    chk("R8 stopped floats", 32'(obs()), 32'(ALL_OFF));
    dir = 1'b1; step(4); dir = 1'b0;
    count_pat(ALL_LOW, 40, n);
    chk("R8 no brake when stopped", 32'(n), 32'd0);
    chk("R8 still floating", 32'(obs()), 32'(ALL_OFF));

    // R12: start without brake, fourth edge
    run_n = 1'b0;
    step(3);
    chk("R12 before fourth edge", 32'(obs()), 32'(ALL_OFF));
    step(1);
    chk("R12 start direct", 32'(obs()), 32'(exp_map(3'b001, 1'b0, 1'b0)));

    // R11: Hall latency of three edges
    hall = 3'b011;
    step(2);
    chk("R11 old after two edges", 32'(obs()), 32'(exp_map(3'b001, 1'b0, 1'b0)));
    step(1);
    chk("R11 new after three edges", 32'(obs()), 32'(exp_map(3'b011, 1'b0, 1'b0)));

    // R2 R3 R5 R6: random clockwise
    for (int i = 0; i < 120; i++) begin
      hall  = 3'($urandom_range(0, 7));
      pwm_n = 1'($urandom_range(0, 1));
      step(5);
      chk("R3/R2/R5 cw map", 32'(obs()), 32'(exp_map(hall, 1'b0, pwm_n)));
      chk("R6 tach", 32'({tach, tach3}), 32'({~hall[2], ~(^hall)}));
    end
    // directed corners
    hall = 3'b111; pwm_n = 1'b1; step(5);
    chk("R2 code 111 recirc", 32'(obs()), 32'(ALL_OFF));
    hall = 3'b000; pwm_n = 1'b0; step(5);
    chk("R2 code 000", 32'(obs()), 32'(ALL_OFF));
    hall = 3'b110; pwm_n = 1'b1; step(5);
    chk("R5 recirc 110", 32'(obs()), 32'(6'b10_10_00));

    // R7: direction flip brake
    hall = 3'b010; pwm_n = 1'b0; step(5);
    dir = 1'b1;
    count_pat(ALL_LOW, 80, n);
    chk("R7 brake length", 32'(n), 32'(BT));
    chk("R4 resumes ccw", 32'(obs()), 32'(exp_map(3'b010, 1'b1, 1'b0)));
    chk("R4 ccw 010 explicit", 32'(obs()), 32'(6'b00_10_01));

    // R4: random counter-clockwise
    for (int i = 0; i < 120; i++) begin
      hall  = 3'($urandom_range(0, 7));
      pwm_n = 1'($urandom_range(0, 1));
      step(5);
      chk("R4 ccw map", 32'(obs()), 32'(exp_map(hall, 1'b1, pwm_n)));
      chk("R6 tach ccw", 32'({tach, tach3}), 32'({~hall[2], ~(^hall)}));
    end

    // R7: flip during brake restarts the timer
    hall = 3'b010; pwm_n = 1'b0; step(5);
    n = 0;
    dir = 1'b0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (i == 4) dir = 1'b1;
      if (obs() == ALL_LOW) n++;
    end
    chk("R7 restart length", 32'(n), 32'(BT + 5));
    chk("R7 resumes ccw", 32'(obs()), 32'(exp_map(3'b010, 1'b1, 1'b0)));

    // R9: current-limit override
    hall = 3'b101; step(5);
    ilim = 1'b1; step(1); ilim = 1'b0;
    count_pat(exp_map(3'b101, 1'b1, 1'b1), 40, n);
    chk("R9 override length", 32'(n), 32'(IT));
    chk("R9 released", 32'(obs()), 32'(exp_map(3'b101, 1'b1, 1'b0)));

    // R10: fault priority
    shrt = 1'b1; step(5);
    chk("R10 short low", 32'(obs()), 32'(ALL_LOW));
    hot = 1'b1; step(5);
    chk("R10 thermal over short", 32'(obs()), 32'(ALL_OFF));
    hot = 1'b0; ilim = 1'b1; step(5);
    chk("R10 short over ilim", 32'(obs()), 32'(ALL_LOW));
    shrt = 1'b0; ilim = 1'b0; step(20);
    chk("R10 recovered", 32'(obs()), 32'(exp_map(3'b101, 1'b1, 1'b0)));

    // R8: stop through brake
    run_n = 1'b1;
    count_pat(ALL_LOW, 80, n);
    chk("R8 stop brake length", 32'(n), 32'(BT));
    chk("R8 floats after stop", 32'(obs()), 32'(ALL_OFF));

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule